// File: doc/BRIEF.md
# Transmit Control Register with Graceful Stop

This block is the single control word that software uses to steer a simple frame transmitter. Through it, software turns the transmitter on, asks for a stop that lets the current frame finish, and decides whether a full status queue should hold up transmission. It can also empty the transmit data queue or the transmit status queue with a one-shot command. The queues and the framing engine live elsewhere. This block drives their flush strobes and reads their level flags. It also exchanges a frame-in-progress signal with the transmitter.

A stop request stays pending until the transmitter reports no frame in progress. At that clock edge the request and the enable both drop together, and the transmitter is then halted. A derived start-permission output tells the transmitter when it may begin a new frame.

Top module: `tx_ctrl_reg`

## Requirements
- R1: After reset, the enable, stop and overrun-allow bits are 0. No flush strobe is high, `sts_full_irq` is 0, and a read at the register offset returns 0.
- R2: The register responds only at address `REG_OFFSET` (default 0x70). A write to any other address changes nothing. A read from any other address returns 0. Reads are combinational on `reg_addr`.
- R3: Writing 1 to bit 15 raises `sts_fifo_flush` for exactly the one cycle after the write. Writing 1 to bit 14 does the same for `dat_fifo_flush`. Both bits always read back as 0.
- R4: Bit 1 is the transmitter enable. It is set or cleared by a write, reads back on bit 1, and is driven on `tx_enable`.
- R5: Bit 0 is the stop request. A write of 1 sets it when no stop is pending. While it is 1, the value written to bit 0 is ignored.
- R6: At the first clock edge where the stop request is 1 and `tx_frame_busy` is 0, the stop bit and the enable bit both clear. This clear wins over a write to bit 1 in the same cycle.
- R7: While `tx_frame_busy` stays 1, a pending stop request and the enable are held.
- R8: `tx_start_ok` is 1 only when all of these hold: the enable is 1, no stop is pending, `dat_fifo_empty` is 0, and either `sts_fifo_full` is 0 or the overrun-allow bit is 1.
- R9: Bit 2 is the overrun-allow bit. It is read/write and reads back on bit 2. All other bits read 0.
- R10: `sts_full_irq` equals `sts_fifo_full` delayed by one cycle, whatever the value of bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational on reg_addr |
| tx_frame_busy | input | 1 | Transmitter has a frame in progress |
| dat_fifo_empty | input | 1 | Transmit data queue is empty |
| sts_fifo_full | input | 1 | Transmit status queue is full |
| dat_fifo_flush | output | 1 | One-cycle flush strobe to the data queue |
| sts_fifo_flush | output | 1 | One-cycle flush strobe to the status queue |
| tx_enable | output | 1 | Transmitter enable |
| tx_start_ok | output | 1 | A new frame may start |
| sts_full_irq | output | 1 | Registered status-full interrupt level |

## Verification
The bench uses the default parameters: an 8-bit address with the register at 0x70 and a 32-bit data word. With an 8-bit address, random stimulus can reach every non-matching address. The stimulus is still weighted toward 0x70, so that stop requests, the hold while busy and completion in the same cycle as a write all occur often. Frame-busy is held high in long random runs. This lets writes to bit 0 arrive while a stop is pending, and it lets status-full and data-empty combinations meet every overrun setting.

// File: rtl/tx_ctrl_pkg.sv
`timescale 1ns/1ps
package tx_ctrl_pkg;
    localparam int BIT_STOP = 0;
    localparam int BIT_EN   = 1;
    localparam int BIT_OVR  = 2;
    localparam int BIT_DFL  = 14;
    localparam int BIT_SFL  = 15;
    localparam int NUM_FLUSH = 2;

    typedef struct packed {
        logic ovr;
        logic en;
        logic stop;
    } ctl_t;
endpackage

// File: rtl/tx_ctrl_flush.sv
`timescale 1ns/1ps
module tx_ctrl_flush #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [N-1:0] req,
    output logic [N-1:0] pulse
);
    logic [N-1:0] pulse_d, pulse_q;

    always_comb begin
        pulse_d = wr_hit ? req : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= pulse_d;
    end

    assign pulse = pulse_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R3: a strobe only follows a write of 1 to its bit
        p_flush_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_q[i] |-> $past(wr_hit && req[i]));
    end
endmodule

// File: rtl/tx_ctrl_stop.sv
`timescale 1ns/1ps
module tx_ctrl_stop
    import tx_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_stop,
    input  logic wr_en,
    input  logic wr_ovr,
    input  logic tx_busy,
    output ctl_t ctl
);
    ctl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_hit) begin
            s_d.en  = wr_en;
            s_d.ovr = wr_ovr;
            if (!s_q.stop) s_d.stop = wr_stop;
        end
        if (s_q.stop && !tx_busy) begin
            s_d.stop = 1'b0;
            s_d.en   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl = s_q;

    // R7: pending stop survives any write while the frame runs
    p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stop && tx_busy |=> s_q.stop);
    // R6: completion clears stop and enable together
    p_stop_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stop && !tx_busy |=> !s_q.stop && !s_q.en);
    // R5: stop rises only from a write
    p_stop_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.stop) |-> $past(wr_hit && wr_stop));
endmodule

// File: rtl/tx_ctrl_gate.sv
`timescale 1ns/1ps
module tx_ctrl_gate
    import tx_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ctl_t ctl,
    input  logic dat_empty,
    input  logic sts_full,
    output logic start_ok,
    output logic irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d    = sts_full;
        start_ok = ctl.en && !ctl.stop && !dat_empty && (!sts_full || ctl.ovr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    // R8: never permit a start without data or while stopping
    p_start_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |-> ctl.en && !ctl.stop && !dat_empty);
    // R10: interrupt level tracks the full flag one cycle late
    p_irq_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_q == $past(sts_full));
endmodule

// File: rtl/tx_ctrl_reg.sv
`timescale 1ns/1ps
module tx_ctrl_reg
    import tx_ctrl_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter int              DATA_W     = 32,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tx_frame_busy,
    input  logic              dat_fifo_empty,
    input  logic              sts_fifo_full,
    output logic              dat_fifo_flush,
    output logic              sts_fifo_flush,
    output logic              tx_enable,
    output logic              tx_start_ok,
    output logic              sts_full_irq
);
    logic                 sel;
    logic                 wr_hit;
    ctl_t                 ctl;
    logic [NUM_FLUSH-1:0] flush_req, flush_pulse;
    logic                 unused_wbits;

    assign sel    = (reg_addr == REG_OFFSET);
    assign wr_hit = reg_wr && sel;

    assign flush_req    = {reg_wdata[BIT_SFL], reg_wdata[BIT_DFL]};
    assign unused_wbits = ^{reg_wdata[DATA_W-1:BIT_SFL+1], reg_wdata[BIT_DFL-1:BIT_OVR+1]};

    tx_ctrl_flush #(.N(NUM_FLUSH)) u_flush (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .req    (flush_req),
        .pulse  (flush_pulse)
    );

    tx_ctrl_stop u_stop (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_stop (reg_wdata[BIT_STOP]),
        .wr_en   (reg_wdata[BIT_EN]),
        .wr_ovr  (reg_wdata[BIT_OVR]),
        .tx_busy (tx_frame_busy),
        .ctl     (ctl)
    );

    tx_ctrl_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .dat_empty (dat_fifo_empty),
        .sts_full  (sts_fifo_full),
        .start_ok  (tx_start_ok),
        .irq       (sts_full_irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel) begin
            reg_rdata[BIT_STOP] = ctl.stop;
            reg_rdata[BIT_EN]   = ctl.en;
            reg_rdata[BIT_OVR]  = ctl.ovr;
        end
    end

    assign dat_fifo_flush = flush_pulse[0];
    assign sts_fifo_flush = flush_pulse[1];
    assign tx_enable      = ctl.en;

    // R2: a write elsewhere leaves the control bits untouched
    p_miss_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !sel && tx_frame_busy |=> $stable(ctl));
endmodule

// File: tb/sim_tx_ctrl_reg.sv
`timescale 1ns/1ps
module sim_tx_ctrl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h70;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy = 1'b0, empty = 1'b1, full = 1'b0;
    logic        dfl, sfl, ten, sok, irq;

    int checks = 0;
    int errors = 0;

    bit m_en = 0, m_stop = 0, m_ovr = 0;
    bit e_dfl = 0, e_sfl = 0, e_irq = 0;

    always #4 clk = ~clk;

    tx_ctrl_reg u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_frame_busy(busy),
        .dat_fifo_empty(empty), .sts_fifo_full(full), .dat_fifo_flush(dfl),
        .sts_fifo_flush(sfl), .tx_enable(ten), .tx_start_ok(sok), .sts_full_irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        return (a == 8'h70) ? {29'd0, m_ovr, m_en, m_stop} : 32'd0;
    endfunction

    function automatic bit exp_ok();
        return m_en && !m_stop && !empty && (!full || m_ovr);
    endfunction

    // one cycle: drive at negedge, check combinational, advance model, check registered
    task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        input bit b, input bit f, input bit e);
        bit hit, n_en, n_stop, n_ovr;
        reg_wr = wr; reg_addr = a; reg_wdata = d; busy = b; full = f; empty = e;
        #1;
        chk("R2/R9 readback", reg_rdata, exp_rd(a));
        chk("R8 start_ok", {31'd0, sok}, {31'd0, exp_ok()});
        hit = wr && (a == 8'h70);
        n_en = m_en; n_stop = m_stop; n_ovr = m_ovr;
        if (hit) begin
            n_en = d[1]; n_ovr = d[2];
            if (!m_stop) n_stop = d[0];
        end
        if (m_stop && !b) begin n_stop = 0; n_en = 0; end
        e_dfl = hit && d[14]; e_sfl = hit && d[15]; e_irq = f;
        m_en = n_en; m_stop = n_stop; m_ovr = n_ovr;
        @(negedge clk);
        chk("R3 data flush", {31'd0, dfl}, {31'd0, e_dfl});
        chk("R3 status flush", {31'd0, sfl}, {31'd0, e_sfl});
        chk("R4/R6 enable", {31'd0, ten}, {31'd0, m_en});
        chk("R10 irq", {31'd0, irq}, {31'd0, e_irq});
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rdata", reg_rdata, 32'd0);
        chk("R1 enable", {31'd0, ten}, 32'd0);
        chk("R1 flush", {30'd0, dfl, sfl}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 miss address write ignored
        step(1, 8'h71, 32'hFFFF_FFFF, 1, 0, 0);
        step(0, 8'h70, 0, 1, 0, 0);
        chk("R2 miss write", reg_rdata, 32'd0);
        // R3 flush both, read back zeros
        step(1, 8'h70, 32'h0000_C006, 0, 0, 0);
        chk("R3 flush reads 0", reg_rdata & 32'h0000_C000, 32'd0);
        // R8/R9 gating with full status queue
        step(1, 8'h70, 32'h2, 0, 1, 0);
        chk("R8 blocked by full", {31'd0, sok}, 32'd0);
        step(1, 8'h70, 32'h6, 0, 1, 0);
        chk("R9 overrun allows", {31'd0, sok}, 32'd1);
        // R5/R7 stop while busy, writes of 0 to bit0 ignored
        step(1, 8'h70, 32'h7, 1, 0, 0);
        step(1, 8'h70, 32'h6, 1, 0, 0);
        chk("R5 stop held after write 0", reg_rdata & 32'h1, 32'h1);
        step(0, 8'h70, 0, 1, 0, 0);
        chk("R7 enable held while busy", {31'd0, ten}, 32'd1);
        // R6 completion beats same-cycle enable write
        step(1, 8'h70, 32'h2, 0, 0, 0);
        chk("R6 stop+en cleared", reg_rdata & 32'h3, 32'h0);
        // R6 stop with idle transmitter clears on next edge
        step(1, 8'h70, 32'h3, 0, 0, 0);
        chk("R6 stop pending", reg_rdata & 32'h3, 32'h3);
        step(0, 8'h70, 0, 0, 0, 0);
        chk("R6 idle halt", reg_rdata & 32'h3, 32'h0);

        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            logic [31:0] d;
            a = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h70;
            d = $urandom;
            step($urandom_range(0, 2) == 0, a, d, $urandom_range(0, 9) < 7,
                 $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule